// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block is the transaction controller of an I2C master. It sits above a bit-level engine and decides which command the engine runs next: start, address byte, data byte write, data byte read, repeated start or stop. A write of the address register while the controller is idle opens a transaction, and the address byte's LSB picks the direction. The write phase drains an external transmit FIFO. The read phase runs until a requested byte count is reached.

If the address register is written again after the current address has begun to go out, the new address is held pending. The current phase then closes with a repeated start followed by the new address, and no stop is sent. A write made before address transmission begins replaces the address of the current transaction instead. An optional 10-bit mode sends a second address byte. A NACK on any written byte cancels the pending address and ends the transaction with a stop.

Top module: `i2c_rs_seq`

## Requirements
- R1: When idle (`busy_o` low), a pulse on `adr0_we_i` starts a transaction. `busy_o` rises on the next cycle and the first command is a start. The next command writes the `adr0_i` byte. `busy_o` falls after the final stop completes.
- R2: Command codes on `cmd_o` are 1 start, 2 repeated start, 3 write byte, 4 read with master ACK, 5 read with master NACK, and 6 stop. `cmd_valid_o` is a one-cycle pulse. No further command is issued until `cmd_done_i` reports completion. No command is issued while idle.
- R3: In the write phase, each data byte is issued as command 3 carrying `tx_data_i`, with `tx_pop_o` high in the same cycle, while `tx_fifo_level_i` is non-zero. When the level is zero and no address is pending, a stop follows.
- R4: In the read phase, reads are issued until `rx_count_i` bytes have been received. Every byte except the last uses command 4, and the last uses command 5. A count of zero issues no read. With no address pending, a stop follows.
- R5: One cycle after each read completes, `rx_req_o` pulses for one cycle and `rx_data_o` carries the received byte.
- R6: `tx_req_o` is high while a write-phase data byte is in flight and the transmit FIFO is empty.
- R7: An address-register write while the start command is outstanding replaces the address byte of the current transaction. No repeated start results from it.
- R8: An address-register write after address transmission has begun is queued. When a write phase empties the FIFO, command 2 is issued instead of a stop, then the queued byte is sent as the address and its LSB sets the new direction.
- R9: A queued address also turns the end of a read phase (count reached) into a repeated start followed by the queued address.
- R10: With `ten_bit_i` high, the `adr0_i` byte is sent as the first address byte and the `adr1_i` byte as the second, before the data phase.
- R11: `ack_i` low at the completion of an address or data write drops any queued address and leads straight to a stop. `nack_o` goes high and stays high until the next transaction starts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adr0_we_i | input | 1 | Address register write strobe |
| adr0_i | input | 8 | Address byte (LSB = direction, 1 = read) |
| adr1_i | input | 8 | Low address byte in 10-bit mode |
| ten_bit_i | input | 1 | 10-bit address mode |
| rx_count_i | input | CNT_W | Bytes to read in a read phase |
| tx_fifo_level_i | input | LVL_W | Transmit FIFO fill level |
| tx_data_i | input | 8 | Transmit FIFO head byte |
| tx_pop_o | output | 1 | Pop the transmit FIFO head |
| cmd_valid_o | output | 1 | Command issue pulse to the bit engine |
| cmd_o | output | 3 | Command code |
| cmd_byte_o | output | 8 | Byte for a write command |
| cmd_done_i | input | 1 | Bit engine finished the command |
| ack_i | input | 1 | Slave acknowledged (valid with done) |
| rx_byte_i | input | 8 | Byte read (valid with done) |
| rx_req_o | output | 1 | Received byte available |
| rx_data_o | output | 8 | Received byte |
| tx_req_o | output | 1 | Write phase needs data |
| busy_o | output | 1 | Transaction in progress |
| nack_o | output | 1 | Last transaction ended on a NACK |

## Verification
The assertions check on every cycle the properties that hold locally. A command is issued only as a single pulse. No command is issued while idle. A FIFO pop always coincides with a write command at a non-zero level. A repeated start is issued only when an address is queued. A NACK always clears the queue. A received-byte pulse always follows a completion. Command ordering can only be shown by the bench's scenarios, which compare whole sequences against a scoreboard. These sequences cover the choice between repeated start and stop, which address byte follows a repeated start, the ACK/NACK choice per read byte, the 10-bit address pair, and the replacement of the address before transmission begins.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE    = 3'd0,
    CMD_START   = 3'd1,
    CMD_RSTART  = 3'd2,
    CMD_WR      = 3'd3,
    CMD_RD_ACK  = 3'd4,
    CMD_RD_NACK = 3'd5,
    CMD_STOP    = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_ADDR2, S_WRITE, S_READ, S_RSTART, S_STOP
  } state_e;
endpackage

// File: rtl/i2c_rs_pend.sv
// Holds a queued address byte until it is consumed by a repeated start or dropped.
module i2c_rs_pend #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  input  logic          accept_i,
  input  logic          consume_i,
  input  logic          drop_i,
  output logic          pend_o,
  output logic [AW-1:0] adr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      adr_o  <= '0;
    end else if (drop_i || consume_i) begin
      pend_o <= 1'b0;
    end else if (we_i && accept_i) begin
      pend_o <= 1'b1;
      adr_o  <= adr_i;
    end
  end
endmodule

// File: rtl/i2c_rs_rxcnt.sv
// Received-byte counter for the read phase.
module i2c_rs_rxcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o,
  output logic             last_o
);
  localparam int XW = CNT_W + 1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o  = (cnt_q == limit_i);
  assign last_o = ((XW'(cnt_q) + XW'(1)) == XW'(limit_i));
endmodule

// File: rtl/i2c_rs_seq.sv
module i2c_rs_seq
  import i2c_rs_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adr0_we_i,
  input  logic [7:0]       adr0_i,
  input  logic [7:0]       adr1_i,
  input  logic             ten_bit_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [LVL_W-1:0] tx_fifo_level_i,
  input  logic [7:0]       tx_data_i,
  output logic             tx_pop_o,
  output logic             cmd_valid_o,
  output logic [2:0]       cmd_o,
  output logic [7:0]       cmd_byte_o,
  input  logic             cmd_done_i,
  input  logic             ack_i,
  input  logic [7:0]       rx_byte_i,
  output logic             rx_req_o,
  output logic [7:0]       rx_data_o,
  output logic             tx_req_o,
  output logic             busy_o,
  output logic             nack_o
);
  state_e     state_q, state_d;
  logic       wait_q;
  logic [7:0] cur_adr_q;
  logic       nack_q, rx_req_q;
  logic [7:0] rx_data_q;
  cmd_e       cmd;
  logic       pend_q, accept, pend_now, consume, wr_nack;
  logic [7:0] pend_adr;
  logic       rx_hit, rx_last, done_ok, fifo_empty, phase_end, is_rd, idle_start;

  assign fifo_empty = (tx_fifo_level_i == '0);
  assign done_ok    = wait_q && cmd_done_i;
  assign is_rd      = cur_adr_q[0];
  assign idle_start = (state_q == S_IDLE) && adr0_we_i;
  assign accept     = (state_q inside {S_ADDR, S_ADDR2, S_WRITE, S_READ, S_RSTART});
  assign pend_now   = pend_q || (adr0_we_i && accept);
  assign consume    = done_ok && (state_q == S_RSTART);
  assign wr_nack    = done_ok && !ack_i && (state_q inside {S_ADDR, S_ADDR2, S_WRITE});
  assign phase_end  = !wait_q && (((state_q == S_WRITE) && fifo_empty) ||
                                  ((state_q == S_READ) && rx_hit));

  i2c_rs_pend #(.AW(8)) u_pend (
    .clk_i, .rst_ni,
    .we_i      (adr0_we_i),
    .adr_i     (adr0_i),
    .accept_i  (accept),
    .consume_i (consume),
    .drop_i    (wr_nack),
    .pend_o    (pend_q),
    .adr_o     (pend_adr)
  );

  i2c_rs_rxcnt #(.CNT_W(CNT_W)) u_rxcnt (
    .clk_i, .rst_ni,
    .clr_i   (idle_start || consume),
    .inc_i   (done_ok && (state_q == S_READ)),
    .limit_i (rx_count_i),
    .hit_o   (rx_hit),
    .last_o  (rx_last)
  );

  // command selection
  always_comb begin
    cmd        = CMD_NONE;
    cmd_byte_o = '0;
    unique case (state_q)
      S_START:  cmd = CMD_START;
      S_ADDR:   begin cmd = CMD_WR; cmd_byte_o = cur_adr_q; end
      S_ADDR2:  begin cmd = CMD_WR; cmd_byte_o = adr1_i; end
      S_WRITE:  if (!fifo_empty) begin cmd = CMD_WR; cmd_byte_o = tx_data_i; end
      S_READ:   if (!rx_hit) cmd = rx_last ? CMD_RD_NACK : CMD_RD_ACK;
      S_RSTART: cmd = CMD_RSTART;
      S_STOP:   cmd = CMD_STOP;
      default:  cmd = CMD_NONE;
    endcase
  end

  assign cmd_valid_o = !wait_q && (cmd != CMD_NONE);
  assign cmd_o       = cmd;
  assign tx_pop_o    = cmd_valid_o && (state_q == S_WRITE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (adr0_we_i) state_d = S_START;
      S_START:  if (done_ok) state_d = S_ADDR;
      S_ADDR:   if (done_ok) state_d = !ack_i ? S_STOP : ten_bit_i ? S_ADDR2 :
                                       is_rd ? S_READ : S_WRITE;
      S_ADDR2:  if (done_ok) state_d = !ack_i ? S_STOP : is_rd ? S_READ : S_WRITE;
      S_WRITE:  if (phase_end) state_d = pend_now ? S_RSTART : S_STOP;
                else if (wr_nack) state_d = S_STOP;
      S_READ:   if (phase_end) state_d = pend_now ? S_RSTART : S_STOP;
      S_RSTART: if (done_ok) state_d = S_ADDR;
      S_STOP:   if (done_ok) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      wait_q    <= 1'b0;
      cur_adr_q <= '0;
      nack_q    <= 1'b0;
      rx_req_q  <= 1'b0;
      rx_data_q <= '0;
    end else begin
      state_q  <= state_d;
      rx_req_q <= done_ok && (state_q == S_READ);
      if (cmd_valid_o)  wait_q <= 1'b1;
      else if (done_ok) wait_q <= 1'b0;
      if (done_ok && (state_q == S_READ)) rx_data_q <= rx_byte_i;
      // address replaced until its transmission begins
      if (adr0_we_i && (state_q inside {S_IDLE, S_START})) cur_adr_q <= adr0_i;
      else if (consume) cur_adr_q <= adr0_we_i ? adr0_i : pend_adr;
      if (idle_start)   nack_q <= 1'b0;
      else if (wr_nack) nack_q <= 1'b1;
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign nack_o    = nack_q;
  assign rx_req_o  = rx_req_q;
  assign rx_data_o = rx_data_q;
  assign tx_req_o  = (state_q == S_WRITE) && wait_q && fifo_empty;
endmodule

// File: rtl/i2c_rs_seq_chk.sv
module i2c_rs_seq_chk
  import i2c_rs_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             adr0_we_i,
  input logic             busy_o,
  input logic             cmd_valid_o,
  input logic [2:0]       cmd_o,
  input logic             cmd_done_i,
  input logic             tx_pop_o,
  input logic [LVL_W-1:0] tx_fifo_level_i,
  input logic             rx_req_o,
  input logic             nack_o,
  input logic             pend_q
);
  a_r1_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && adr0_we_i) |=> (busy_o && cmd_valid_o && cmd_o == CMD_START));

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o);

  a_r3_pop_with_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> (cmd_valid_o && cmd_o == CMD_WR && tx_fifo_level_i != '0));

  a_r5_rx_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_req_o |-> $past(cmd_done_i));

  a_r8_rstart_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == CMD_RSTART) |-> pend_q);

  a_r11_nack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nack_o) |-> (!pend_q && busy_o));
endmodule

bind i2c_rs_seq i2c_rs_seq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i, .rst_ni, .adr0_we_i, .busy_o, .cmd_valid_o, .cmd_o, .cmd_done_i,
  .tx_pop_o, .tx_fifo_level_i, .rx_req_o, .nack_o, .pend_q(pend_q)
);

// File: tb/test_i2c_rs_seq.sv
module test_i2c_rs_seq;
  import i2c_rs_pkg::*;
  localparam int CNT_W = 8;
  localparam int LVL_W = 5;
  localparam int LAT   = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic adr0_we_i = 1'b0, ten_bit_i = 1'b0;
  logic [7:0] adr0_i = '0, adr1_i = '0, tx_data_i = '0, rx_byte_i = '0;
  logic [CNT_W-1:0] rx_count_i = '0;
  logic [LVL_W-1:0] tx_fifo_level_i = '0;
  logic cmd_done_i = 1'b0, ack_i = 1'b1;
  logic tx_pop_o, cmd_valid_o, rx_req_o, tx_req_o, busy_o, nack_o;
  logic [2:0] cmd_o;
  logic [7:0] cmd_byte_o, rx_data_o;

  always #5 clk_i = ~clk_i;

  i2c_rs_seq #(.CNT_W(CNT_W), .LVL_W(LVL_W)) i_i2c_rs_seq (.*);

  int errors = 0, checks = 0;
  byte unsigned fifo_q[$], rd_q[$], exp_rx[$];
  logic [10:0] exp_cmd[$];   // {tag[1:0], cmd[2:0], byte[7:0]} minus tag
  string exp_tag[$];
  logic pop_pend = 1'b0, nack_arm = 1'b0;
  int eng_cnt = 0;
  logic [2:0] eng_cmd;
  logic [2:0] seen_cmd;
  logic [7:0] seen_byte;
  event seen;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void sync_fifo();
    tx_fifo_level_i = LVL_W'(fifo_q.size());
    tx_data_i = (fifo_q.size() != 0) ? fifo_q[0] : 8'h00;
  endfunction

  task automatic expect_cmd(input cmd_e c, input logic [7:0] b, input string tag);
    exp_cmd.push_back({c, b});
    exp_tag.push_back(tag);
  endtask

  // monitor and bit-engine model
  always @(negedge clk_i) begin
    if (pop_pend) begin void'(fifo_q.pop_front()); pop_pend = 1'b0; sync_fifo(); end
    cmd_done_i = 1'b0;
    if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        cmd_done_i = 1'b1;
        ack_i = 1'b1;
        if (eng_cmd == CMD_WR && nack_arm) begin ack_i = 1'b0; nack_arm = 1'b0; end
        if (eng_cmd == CMD_RD_ACK || eng_cmd == CMD_RD_NACK)
          rx_byte_i = (rd_q.size() != 0) ? rd_q.pop_front() : 8'hEE;
      end
    end
    if (cmd_valid_o) begin
      logic [10:0] e;
      string t;
      if (exp_cmd.size() == 0) chk(1'b0, "R2 unexpected command", int'(cmd_o), 0);
      else begin
        e = exp_cmd.pop_front();
        t = exp_tag.pop_front();
        chk(cmd_o == e[10:8], t, int'(cmd_o), int'(e[10:8]));
        if (e[10:8] == CMD_WR)
          chk(cmd_byte_o == e[7:0], {t, " byte"}, int'(cmd_byte_o), int'(e[7:0]));
      end
      eng_cnt = LAT;
      eng_cmd = cmd_o;
      seen_cmd = cmd_o;
      seen_byte = cmd_byte_o;
      if (tx_pop_o) pop_pend = 1'b1;
      -> seen;
    end
    if (rx_req_o) begin
      if (exp_rx.size() == 0) chk(1'b0, "R5 unexpected rx_req", int'(rx_data_o), 0);
      else begin
        byte unsigned x;
        x = exp_rx.pop_front();
        chk(rx_data_o == x, "R5 rx data", int'(rx_data_o), int'(x));
      end
    end
  end

  task automatic start_txn(input logic [7:0] a);
    @(negedge clk_i);
    adr0_i = a; adr0_we_i = 1'b1;
    @(negedge clk_i);
    adr0_we_i = 1'b0;
  endtask

  task automatic wait_seen(input cmd_e c, input logic [7:0] b);
    do @(seen); while (!(seen_cmd == c && (c != CMD_WR || seen_byte == b)));
  endtask

  task automatic queue_addr(input logic [7:0] a);
    @(negedge clk_i);
    adr0_i = a; adr0_we_i = 1'b1;
    @(negedge clk_i);
    adr0_we_i = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    do @(negedge clk_i); while (busy_o);
    repeat (2) @(negedge clk_i);
    chk(exp_cmd.size() == 0, {tag, " all commands seen"}, exp_cmd.size(), 0);
    chk(exp_rx.size() == 0, {tag, " all rx bytes seen"}, exp_rx.size(), 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    sync_fifo();
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !cmd_valid_o && !nack_o && !rx_req_o, "R1 reset state",
        {busy_o, cmd_valid_o, nack_o, rx_req_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 R3 R6: plain write, two bytes
    fifo_q = '{8'h11, 8'h22}; sync_fifo();
    expect_cmd(CMD_START, 0, "R1 start");
    expect_cmd(CMD_WR, 8'hA0, "R1 address");
    expect_cmd(CMD_WR, 8'h11, "R3 data0");
    expect_cmd(CMD_WR, 8'h22, "R3 data1");
    expect_cmd(CMD_STOP, 0, "R3 stop");
    start_txn(8'hA0);
    chk(busy_o, "R1 busy after start", busy_o, 1);
    wait_seen(CMD_WR, 8'h22);
    repeat (2) @(negedge clk_i);
    chk(tx_req_o, "R6 tx_req while empty and byte in flight", tx_req_o, 1);
    wait_idle("R3");
    chk(!busy_o, "R1 busy low at end", busy_o, 0);

    // R8 R4 R5: write, repeated start, read of two
    fifo_q = '{8'h33}; sync_fifo();
    rx_count_i = 8'd2;
    rd_q = '{8'h5A, 8'h5B};
    exp_rx = '{8'h5A, 8'h5B};
    expect_cmd(CMD_START, 0, "R8 start");
    expect_cmd(CMD_WR, 8'hA0, "R8 address");
    expect_cmd(CMD_WR, 8'h33, "R8 data");
    expect_cmd(CMD_RSTART, 0, "R8 repeated start");
    expect_cmd(CMD_WR, 8'hA1, "R8 queued address");
    expect_cmd(CMD_RD_ACK, 0, "R4 read ack");
    expect_cmd(CMD_RD_NACK, 0, "R4 read last nack");
    expect_cmd(CMD_STOP, 0, "R4 stop");
    start_txn(8'hA0);
    wait_seen(CMD_WR, 8'hA0);
    queue_addr(8'hA1);
    wait_idle("R8");

    // R7: write during start replaces the address
    fifo_q.delete(); sync_fifo();
    expect_cmd(CMD_START, 0, "R7 start");
    expect_cmd(CMD_WR, 8'h52, "R7 replaced address");
    expect_cmd(CMD_STOP, 0, "R7 stop, no repeated start");
    @(negedge clk_i);
    adr0_i = 8'h50; adr0_we_i = 1'b1;
    @(negedge clk_i);
    adr0_i = 8'h52;
    @(negedge clk_i);
    adr0_we_i = 1'b0;
    wait_idle("R7");

    // R11: nack on address drops queued address
    fifo_q = '{8'h44}; sync_fifo();
    nack_arm = 1'b1;
    expect_cmd(CMD_START, 0, "R11 start");
    expect_cmd(CMD_WR, 8'hA0, "R11 address");
    expect_cmd(CMD_STOP, 0, "R11 stop after nack");
    start_txn(8'hA0);
    wait_seen(CMD_WR, 8'hA0);
    queue_addr(8'hA1);
    wait_idle("R11");
    chk(nack_o, "R11 nack flag set", nack_o, 1);
    chk(tx_fifo_level_i == 1, "R11 data byte not sent", tx_fifo_level_i, 1);

    // R10: 10-bit address, also clears nack (R11)
    ten_bit_i = 1'b1; adr1_i = 8'h34;
    fifo_q = '{8'h44}; sync_fifo();
    expect_cmd(CMD_START, 0, "R10 start");
    expect_cmd(CMD_WR, 8'hF2, "R10 first address byte");
    expect_cmd(CMD_WR, 8'h34, "R10 second address byte");
    expect_cmd(CMD_WR, 8'h44, "R10 data");
    expect_cmd(CMD_STOP, 0, "R10 stop");
    start_txn(8'hF2);
    chk(!nack_o, "R11 nack cleared on new start", nack_o, 0);
    wait_idle("R10");
    ten_bit_i = 1'b0;

    // R4: read count zero
    rx_count_i = 8'd0;
    expect_cmd(CMD_START, 0, "R4 start");
    expect_cmd(CMD_WR, 8'h91, "R4 address");
    expect_cmd(CMD_STOP, 0, "R4 zero count stop");
    start_txn(8'h91);
    wait_idle("R4 zero");

    // R9: read of one, repeated start, write
    rx_count_i = 8'd1;
    rd_q = '{8'hC3}; exp_rx = '{8'hC3};
    fifo_q = '{8'h66}; sync_fifo();
    expect_cmd(CMD_START, 0, "R9 start");
    expect_cmd(CMD_WR, 8'h91, "R9 address");
    expect_cmd(CMD_RD_NACK, 0, "R9 single read nack");
    expect_cmd(CMD_RSTART, 0, "R9 repeated start");
    expect_cmd(CMD_WR, 8'h90, "R9 queued address");
    expect_cmd(CMD_WR, 8'h66, "R9 data");
    expect_cmd(CMD_STOP, 0, "R9 stop");
    start_txn(8'h91);
    wait_seen(CMD_WR, 8'h91);
    queue_addr(8'h90);
    wait_idle("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule